// File: doc/BRIEF.md
# Accumulator ALU with Condition Flags

This block is the arithmetic and logic datapath of an 8-bit accumulator machine. It takes two operands and an operation code and returns the result in the same cycle. It also keeps a five-bit condition-code register, which changes on the next rising clock edge. Each operation works at one of two widths. At 8 bits it uses the low byte of each operand, as when the source is accumulator A or B. At 16 bits it uses the full operand, as when the source is the accumulator pair D, with A in the high byte and B in the low byte.

The surrounding core decodes instructions and fetches operands. It uses `wr_en` to decide whether the result goes back to a register, and it drops `flag_en` for operations that must leave the flags alone, such as stack push and pull. The rotates take their incoming bit from the stored carry flag. Add-with-carry and subtract-with-borrow take theirs from the `carry_in` pin.

Top module: `acc_alu`

## Requirements
- R1: After reset all flags are 0. The `flags` bit layout is C=bit 0, V=bit 1, Z=bit 2, N=bit 3, H=bit 4.
- R2: Op 0 (add) gives a+b and op 1 (add with carry) gives a+b+carry_in. C is the carry out of the top bit of the selected width. V is set when both operands have the same sign and the result's sign differs from it. When `wide`=0 only the low bytes are used, and result[15:8] is 0.
- R3: H takes the carry out of bit 3 only on ops 0 and 1 with `wide`=0. Every other operation leaves H unchanged.
- R4: Op 2 (subtract) gives a-b and op 3 (subtract with borrow) gives a-b-carry_in. C is set when the unsigned subtraction borrows. V is set when the operand signs differ and the result's sign differs from a.
- R5: Op 4 (compare) sets C, V, Z and N exactly as op 2 does, and holds `wr_en` at 0.
- R6: Op 5 gives a AND b, op 6 gives a OR b, op 7 gives a XOR b, and op 8 gives the ones complement of a. All four clear V and leave C unchanged.
- R7: Op 9 shifts a left with 0 in, op 10 shifts it right logically, and op 11 shifts it right arithmetically. C receives the bit shifted out, and V becomes N XOR C.
- R8: Op 12 rotates a left and op 13 rotates it right, at either width, through the stored C. The old C enters the vacated end, the bit leaving the other end becomes C, and V becomes N XOR C.
- R9: Z is set when every bit of the result at the selected width is 0. N copies the top bit of the result at that width.
- R10: With `flag_en`=0 the flags hold their value. Ops 14 and 15 do nothing: `wr_en` is 0 and the flags hold.
- R11: `result` and `wr_en` follow the inputs combinationally. Flags take their new value at the next rising edge of `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_a | input | 16 | First operand (only the low byte is used when `wide`=0) |
| op_b | input | 16 | Second operand |
| op_sel | input | 4 | Operation code |
| wide | input | 1 | 1 = 16-bit operation, 0 = 8-bit operation |
| carry_in | input | 1 | Incoming carry or borrow for ops 1 and 3 |
| flag_en | input | 1 | Allows the flags to update at the next edge |
| result | output | 16 | Result, zero-extended at 8 bits |
| wr_en | output | 1 | Result is to be written back |
| flags | output | 5 | Condition codes {H,N,Z,V,C} |

## Verification
`result` and `wr_en` are due in the same cycle as the inputs that produce them. The bench therefore drives at the falling edge and compares them one nanosecond later, before the next rising edge. The flags are due one edge later. The bench's reference model updates its own flag copy only after that rising edge, and compares it with `flags` at the next falling edge. This is also where a held or unchanged flag is caught. Rotates read the stored carry, so the model's carry produced by one step feeds the expected value of the next.

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2*BYTE_W-1:0] op_a,
  input  logic [2*BYTE_W-1:0] op_b,
  input  logic [3:0]          op_sel,
  input  logic                wide,
  input  logic                carry_in,
  input  logic                flag_en,
  output logic [2*BYTE_W-1:0] result,
  output logic                wr_en,
  output logic [4:0]          flags
);
  localparam int W   = 2 * BYTE_W;
  localparam int NIB = BYTE_W / 2;

  localparam logic [3:0] OP_ADD = 4'd0,  OP_ADC = 4'd1,  OP_SUB = 4'd2,  OP_SBC = 4'd3;
  localparam logic [3:0] OP_CMP = 4'd4,  OP_AND = 4'd5,  OP_OR  = 4'd6,  OP_XOR = 4'd7;
  localparam logic [3:0] OP_COM = 4'd8,  OP_LSL = 4'd9,  OP_LSR = 4'd10, OP_ASR = 4'd11;
  localparam logic [3:0] OP_ROL = 4'd12, OP_ROR = 4'd13;

  logic [W-1:0] a, b, r_raw, r_m, tbit;
  logic [W:0]   add_s, sub_s, cin_x;
  logic [NIB:0] half;
  logic         a_t, b_t, r_t, c_n, v_n, h_n, upd;

  assign a     = wide ? op_a : {{BYTE_W{1'b0}}, op_a[BYTE_W-1:0]};
  assign b     = wide ? op_b : {{BYTE_W{1'b0}}, op_b[BYTE_W-1:0]};
  assign tbit  = wide ? (W'(1) << (W-1)) : (W'(1) << (BYTE_W-1));
  assign a_t   = |(a & tbit);
  assign b_t   = |(b & tbit);
  assign cin_x = {{W{1'b0}}, carry_in & (op_sel == OP_ADC || op_sel == OP_SBC)};
  assign add_s = {1'b0, a} + {1'b0, b} + cin_x;
  assign sub_s = {1'b0, a} - {1'b0, b} - cin_x;
  assign half  = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]} + cin_x[NIB:0];

  always_comb begin
    r_raw = '0;
    c_n   = flags[0];
    upd   = 1'b1;
    wr_en = 1'b1;
    case (op_sel)
      OP_ADD, OP_ADC: begin
        r_raw = add_s[W-1:0];
        c_n   = wide ? add_s[W] : add_s[BYTE_W];
      end
      OP_SUB, OP_SBC, OP_CMP: begin
        r_raw = sub_s[W-1:0];
        c_n   = sub_s[W];
        wr_en = (op_sel != OP_CMP);
      end
      OP_AND: r_raw = a & b;
      OP_OR:  r_raw = a | b;
      OP_XOR: r_raw = a ^ b;
      OP_COM: r_raw = ~a;
      OP_LSL: begin r_raw = a << 1; c_n = a_t; end
      OP_LSR: begin r_raw = a >> 1; c_n = a[0]; end
      OP_ASR: begin r_raw = (a >> 1) | (a_t ? tbit : '0); c_n = a[0]; end
      OP_ROL: begin r_raw = (a << 1) | W'(flags[0]); c_n = a_t; end
      OP_ROR: begin r_raw = (a >> 1) | (flags[0] ? tbit : '0); c_n = a[0]; end
      default: begin upd = 1'b0; wr_en = 1'b0; end
    endcase
  end

  assign r_m    = wide ? r_raw : {{BYTE_W{1'b0}}, r_raw[BYTE_W-1:0]};
  assign r_t    = |(r_m & tbit);
  assign result = r_m;

  always_comb begin
    v_n = flags[1];
    h_n = flags[4];
    case (op_sel)
      OP_ADD, OP_ADC: begin
        v_n = (a_t == b_t) && (r_t != a_t);
        if (!wide) h_n = half[NIB];
      end
      OP_SUB, OP_SBC, OP_CMP: v_n = (a_t != b_t) && (r_t != a_t);
      OP_AND, OP_OR, OP_XOR, OP_COM: v_n = 1'b0;
      OP_LSL, OP_LSR, OP_ASR, OP_ROL, OP_ROR: v_n = r_t ^ c_n;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flags <= '0;
    else if (flag_en && upd)
      flags <= {h_n, r_t, ~|r_m, v_n, c_n};
  end
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
  parameter int BYTE_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic [2*BYTE_W-1:0] op_a,
  input logic [2*BYTE_W-1:0] op_b,
  input logic [3:0]          op_sel,
  input logic                wide,
  input logic                carry_in,
  input logic                flag_en,
  input logic [2*BYTE_W-1:0] result,
  input logic                wr_en,
  input logic [4:0]          flags
);
  localparam int W = 2 * BYTE_W;

  assert_flags_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_en |=> $stable(flags));

  assert_nop_inert_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel >= 4'd14) |=> $stable(flags));

  assert_nop_nowrite_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel >= 4'd14) |-> !wr_en);

  assert_cmp_nowrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 4'd4) |-> !wr_en);

  assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wide |-> (result[W-1:BYTE_W] == '0));

  assert_zero_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_en && op_sel < 4'd14) |=> (flags[2] == ($past(result) == '0)));

  assert_neg_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_en && op_sel < 4'd14) |=>
      (flags[3] == ($past(wide) ? $past(result[W-1]) : $past(result[BYTE_W-1]))));

  assert_logic_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_en && op_sel >= 4'd5 && op_sel <= 4'd8) |=>
      (!flags[1] && flags[0] == $past(flags[0])));

  assert_half_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_sel <= 4'd1 && !wide) |=> (flags[4] == $past(flags[4])));
endmodule

bind acc_alu acc_alu_chk #(.BYTE_W(BYTE_W)) i_acc_alu_chk (.*);

// File: tb/test_acc_alu.sv
`timescale 1ns/1ps
module test_acc_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] op_a = '0, op_b = '0;
  logic [3:0]  op_sel = 4'd15;
  logic        wide = 1'b0, carry_in = 1'b0, flag_en = 1'b0;
  logic [15:0] result;
  logic        wr_en;
  logic [4:0]  flags;

  int n_run = 0, n_fail = 0;
  int m_c = 0, m_v = 0, m_z = 0, m_n = 0, m_h = 0;
  bit done = 0;

  always #2 clk = ~clk;

  acc_alu i_acc_alu (.clk, .rst_n, .op_a, .op_b, .op_sel, .wide, .carry_in,
                     .flag_en, .result, .wr_en, .flags);

  function automatic int mflags();
    return (m_h << 4) | (m_n << 3) | (m_z << 2) | (m_v << 1) | m_c;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, int op, int a_in, int b_in, bit w, bit ci, bit fe);
    int width, mask, msb, a, b, s, r, c, v, h, upd, wr;
    @(negedge clk);
    op_sel = 4'(op); op_a = 16'(a_in); op_b = 16'(b_in);
    wide = w; carry_in = ci; flag_en = fe;
    #1;
    width = w ? 16 : 8;
    mask = (1 << width) - 1;
    msb = 1 << (width - 1);
    a = a_in & mask; b = b_in & mask;
    c = m_c; v = m_v; h = m_h; upd = 1; wr = 1; r = 0;
    case (op)
      0, 1: begin
        s = a + b + ((op == 1) ? int'(ci) : 0);
        r = s & mask; c = (s > mask);
        v = ((a ^ r) & (b ^ r) & msb) != 0;
        if (!w) h = (((a & 15) + (b & 15) + ((op == 1) ? int'(ci) : 0)) > 15);
      end
      2, 3, 4: begin
        s = a - b - ((op == 3) ? int'(ci) : 0);
        r = s & mask; c = (s < 0);
        v = ((a ^ b) & (a ^ r) & msb) != 0;
        if (op == 4) wr = 0;
      end
      5: begin r = a & b; v = 0; end
      6: begin r = a | b; v = 0; end
      7: begin r = a ^ b; v = 0; end
      8: begin r = ~a & mask; v = 0; end
      9:  begin r = (a * 2) & mask; c = (a & msb) != 0; end
      10: begin r = a / 2; c = a % 2; end
      11: begin r = (a / 2) | (a & msb); c = a % 2; end
      12: begin r = ((a * 2) & mask) + m_c; c = (a & msb) != 0; end
      13: begin r = (a / 2) + (m_c ? msb : 0); c = a % 2; end
      default: begin upd = 0; wr = 0; end
    endcase
    if (op >= 9 && op <= 13) v = ((r & msb) != 0) ^ c;
    if (wr) check(tag, "result", int'(result), r);
    check(tag, "wr_en", int'(wr_en), wr);
    check("R11", "flags before edge", int'(flags), mflags());
    @(posedge clk);
    if (fe && upd) begin
      m_c = c; m_v = v; m_h = h;
      m_z = (r == 0); m_n = (r & msb) != 0;
    end
  endtask

  function automatic string tag_of(int op);
    case (op)
      0, 1: return "R2";
      2, 3: return "R4";
      4: return "R5";
      5, 6, 7, 8: return "R6";
      9, 10, 11: return "R7";
      12, 13: return "R8";
      default: return "R10";
    endcase
  endfunction

  initial begin
    #400000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1 check("R1", "reset flags", int'(flags), 0);
    // R2 add at both widths
    step("R2", 0, 'h7F, 'h01, 0, 0, 1);
    step("R2", 1, 'hFF, 'h00, 0, 1, 1);
    step("R2", 0, 'hFFFF, 'h0001, 1, 0, 1);
    step("R2", 0, 'h1234, 'h5678, 1, 0, 1);
    // R3 half carry, then held through 16-bit add and subtract
    step("R3", 0, 'h0F, 'h01, 0, 0, 1);
    step("R3", 0, 'h0F00, 'h0F00, 1, 0, 1);
    step("R3", 2, 'h10, 'h01, 0, 0, 1);
    step("R3", 0, 'h01, 'h01, 0, 0, 1);
    // R4 subtract, borrow and overflow
    step("R4", 2, 'h00, 'h01, 0, 0, 1);
    step("R4", 3, 'h80, 'h00, 0, 1, 1);
    step("R4", 2, 'h8000, 'h0001, 1, 0, 1);
    // R5 compare
    step("R5", 4, 'h05, 'h05, 0, 0, 1);
    step("R5", 4, 'h1000, 'h2000, 1, 0, 1);
    // R6 logic keeps C from previous borrow
    step("R6", 5, 'hF0, 'h3C, 0, 0, 1);
    step("R6", 8, 'h00FF, 0, 1, 0, 1);
    step("R6", 7, 'hAA, 'hAA, 0, 0, 1);
    // R7 shifts
    step("R7", 9, 'h81, 0, 0, 0, 1);
    step("R7", 11, 'h8001, 0, 1, 0, 1);
    step("R7", 10, 'h01, 0, 0, 0, 1);
    // R8 rotate chain through C
    step("R8", 12, 'h80, 0, 0, 0, 1);
    step("R8", 12, 'h00, 0, 0, 0, 1);
    step("R8", 13, 'h0001, 0, 1, 0, 1);
    step("R8", 13, 'h0000, 0, 1, 0, 1);
    // R9 zero and negative at each width
    step("R9", 0, 'h0080, 'h0080, 0, 0, 1);
    step("R9", 0, 'h7FFF, 'h0001, 1, 0, 1);
    // R10 hold and no-op codes
    step("R10", 2, 'h00, 'h01, 0, 0, 0);
    step("R10", 14, 'h12, 'h34, 0, 0, 1);
    step("R10", 15, 'h00, 'h00, 1, 1, 1);
    step("R10", 0, 'h00, 'h00, 0, 0, 1);
    for (int i = 0; i < 400; i++) begin
      int op;
      op = int'($urandom_range(0, 15));
      step(tag_of(op), op, int'($urandom & 32'hFFFF), int'($urandom & 32'hFFFF),
           1'($urandom), 1'($urandom), ($urandom_range(0, 7) != 0));
    end
    @(negedge clk);
    check("R11", "final flags", int'(flags), mflags());
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule